// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Line Status

This block sits on the receive side of a 16550-class serial port, between the deserialiser and the processor bus. Every received character is pushed together with three error tags: parity, framing and break. The tags travel through the queue with their character. The block builds a read-only line status byte from the character at the head of the queue, a sticky overrun flag and two transmitter indications supplied from outside. It also drives a receiver line-status interrupt.

Two operating modes are supported. In queue mode the storage holds up to `DEPTH` characters, and a summary bit reports whether any errored character is still waiting. In single-register mode only one character is held and the summary bit stays low. Reading the status byte acknowledges the errors of the current head character and clears the overrun flag. Reading the data byte removes the head character.

Top module: `rx_line_status_unit`

## Requirements
- R1: After reset the queue is empty, status bits 7 and 4..0 are 0, and `line_irq` is 0.
- R2: In queue mode up to `DEPTH` (default 16) characters are held and read out in arrival order. `rx_data` shows the head character. Status bit 0 (data ready) is 1 while the queue is not empty. A data read strobe removes the head character.
- R3: Status bits 4, 3 and 2 show the break, framing and parity tags of the head character, and of no other entry. They are shown only until that character is acknowledged.
- R4: A status read strobe acknowledges the head character, which forces bits 4..2 to 0 until a new character becomes head. The same strobe also clears overrun bit 1.
- R5: In queue mode, bit 7 is 1 while at least one stored character carries a tag and has not been acknowledged. A status read leaves bit 7 at 1 when other tagged characters remain in the queue.
- R6: In single-register mode one character is held and bit 7 is always 0.
- R7: A character that arrives while storage is full, with no data read in the same cycle, is discarded and sets overrun bit 1. A character that arrives while storage is full together with a data read is accepted.
- R8: When a status read and a new tagged or discarded character fall in the same cycle, the new condition stays visible after the read.
- R9: `line_irq` is 1 exactly when `irq_en` is 1 and at least one of status bits 4..1 is 1.
- R10: The status write strobe has no effect on any status bit or on the stored data.
- R11: Any change of `fifo_mode` empties the storage and clears overrun and acknowledge state in the next cycle.
- R12: Status bit 6 follows `tx_shift_empty` and bit 5 follows `tx_hold_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = queue mode, 0 = single-register mode |
| irq_en | input | 1 | Line-status interrupt enable |
| wr_valid | input | 1 | A received character is presented this cycle |
| wr_data | input | 8 | Received character |
| wr_parity_err | input | 1 | Parity tag of the character |
| wr_frame_err | input | 1 | Framing tag of the character |
| wr_break | input | 1 | Break tag of the character |
| rd_data_strb | input | 1 | Processor reads the data byte (removes head) |
| rd_status_strb | input | 1 | Processor reads the status byte |
| wr_status_strb | input | 1 | Processor writes the status byte (ignored) |
| tx_shift_empty | input | 1 | Transmitter fully idle, shown on bit 6 |
| tx_hold_empty | input | 1 | Transmit holding stage empty, shown on bit 5 |
| rx_data | output | 8 | Head character |
| line_status | output | 8 | Line status byte |
| line_irq | output | 1 | Receiver line-status interrupt |

## Verification
A vector sequence interleaves clean and tagged characters, so that the head tags can be told apart from tags buried deeper in the queue. It includes status reads with a clean head while tagged entries wait behind it, which separates the summary bit from the head bits. Directed cases fill the queue to its limit and then push with and without a simultaneous data read, which distinguishes discard from acceptance. The same cases verify arrival order across a pointer wrap. Further cases place a status read in the same cycle as a new condition, switch modes with characters stored, and pulse the status write strobe and the interrupt enable with a tagged head, checking that the strobe changes nothing.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int DATA_W = 8;

  // error tags that travel with each character
  typedef struct packed {
    logic brk;
    logic frame;
    logic parity;
  } rx_err_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    rx_err_t           err;
  } rx_entry_t;

  // line status bit positions (decoded by software)
  localparam int LS_READY   = 0;
  localparam int LS_OVERRUN = 1;
  localparam int LS_PARITY  = 2;
  localparam int LS_FRAME   = 3;
  localparam int LS_BREAK   = 4;
  localparam int LS_THOLD   = 5;
  localparam int LS_TIDLE   = 6;
  localparam int LS_QERR    = 7;

endpackage

// File: rtl/rxs_reset_sync.sv
module rxs_reset_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_out_n = sync_q[1];

endmodule

// File: rtl/rxs_queue.sv
module rxs_queue
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              fifo_mode,
  input  logic                              push_req,
  input  rx_entry_t                         push_entry,
  input  logic                              pop_req,
  output rx_entry_t                         head_entry,
  output logic                              empty,
  output logic                              full,
  output logic                              pop_ok,
  output logic                              overflow,
  output logic [$clog2(DEPTH+1)-1:0]        count,
  output logic [$clog2(DEPTH+1)-1:0]        err_count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] errc_q, errc_d;
  logic [CNT_W-1:0] limit;
  logic             push_ok;
  logic             push_tagged;
  logic             head_tagged;
  rx_entry_t        slot_arr [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // single-register mode limits the storage to one entry
  assign limit       = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign empty       = (cnt_q == '0);
  assign full        = (cnt_q >= limit);
  assign pop_ok      = pop_req && !empty;
  assign push_ok     = push_req && (!full || pop_ok);
  assign overflow    = push_req && full && !pop_ok;
  assign head_entry  = slot_arr[rd_ptr_q];
  assign push_tagged = |push_entry.err;
  assign head_tagged = |head_entry.err;
  assign count       = cnt_q;
  assign err_count   = errc_q;

  // storage slots
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rx_entry_t slot_q;
    logic      slot_we;

    assign slot_we = push_ok && (wr_ptr_q == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_we) begin
        slot_q <= push_entry;
      end
    end

    assign slot_arr[g] = slot_q;
  end

  // next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    errc_d   = errc_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
      errc_d   = '0;
    end else begin
      if (push_ok) begin
        wr_ptr_d = ptr_next(wr_ptr_q);
      end
      if (pop_ok) begin
        rd_ptr_d = ptr_next(rd_ptr_q);
      end
      cnt_d  = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      errc_d = errc_q + CNT_W'(push_ok && push_tagged)
                      - CNT_W'(pop_ok && head_tagged);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      errc_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      errc_q   <= errc_d;
    end
  end

endmodule

// File: rtl/rxs_status_gen.sv
module rxs_status_gen
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         fifo_mode,
  input  logic                         irq_en,
  input  logic                         status_rd,
  input  logic                         pop_ok,
  input  logic                         overflow,
  input  logic                         empty,
  input  rx_err_t                      head_err,
  input  logic [$clog2(DEPTH+1)-1:0]   err_count,
  input  logic                         tx_shift_empty,
  input  logic                         tx_hold_empty,
  output logic [7:0]                   line_status,
  output logic                         line_irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             ack_q, ack_d;
  logic             ovr_q, ovr_d;
  rx_err_t          shown;
  logic [CNT_W-1:0] pending;

  // acknowledge state of the current head character
  always_comb begin
    ack_d = ack_q;
    if (flush || pop_ok) begin
      ack_d = 1'b0;
    end else if (status_rd && !empty) begin
      ack_d = 1'b1;
    end
  end

  // sticky overrun: a new overrun beats a simultaneous read
  always_comb begin
    ovr_d = ovr_q;
    if (flush) begin
      ovr_d = 1'b0;
    end else if (overflow) begin
      ovr_d = 1'b1;
    end else if (status_rd) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      ovr_q <= ovr_d;
    end
  end

  assign shown   = (!empty && !ack_q) ? head_err : '0;
  assign pending = err_count - CNT_W'(ack_q && (|head_err));

  always_comb begin
    line_status             = '0;
    line_status[LS_READY]   = !empty;
    line_status[LS_OVERRUN] = ovr_q;
    line_status[LS_PARITY]  = shown.parity;
    line_status[LS_FRAME]   = shown.frame;
    line_status[LS_BREAK]   = shown.brk;
    line_status[LS_THOLD]   = tx_hold_empty;
    line_status[LS_TIDLE]   = tx_shift_empty;
    line_status[LS_QERR]    = fifo_mode && (pending != '0);
  end

  assign line_irq = irq_en && (|line_status[LS_BREAK:LS_OVERRUN]);

endmodule

// File: rtl/rx_line_status_unit.sv
module rx_line_status_unit
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_parity_err,
  input  logic              wr_frame_err,
  input  logic              wr_break,
  input  logic              rd_data_strb,
  input  logic              rd_status_strb,
  input  logic              wr_status_strb,
  input  logic              tx_shift_empty,
  input  logic              tx_hold_empty,
  output logic [DATA_W-1:0] rx_data,
  output logic [7:0]        line_status,
  output logic              line_irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_sync_n;
  logic             mode_q;
  logic             flush;
  rx_entry_t        in_entry;
  rx_entry_t        head_entry;
  logic             q_empty;
  logic             q_full;
  logic             q_pop_ok;
  logic             q_overflow;
  logic [CNT_W-1:0] q_count;
  logic [CNT_W-1:0] q_err_count;

  rxs_reset_sync u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  // mode change detection drives a one-cycle flush
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= fifo_mode;
    end
  end

  assign flush            = (fifo_mode != mode_q);
  assign in_entry.data    = wr_data;
  assign in_entry.err     = '{brk: wr_break, frame: wr_frame_err, parity: wr_parity_err};

  rxs_queue #(.DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush      (flush),
    .fifo_mode  (fifo_mode),
    .push_req   (wr_valid && !flush),
    .push_entry (in_entry),
    .pop_req    (rd_data_strb && !flush),
    .head_entry (head_entry),
    .empty      (q_empty),
    .full       (q_full),
    .pop_ok     (q_pop_ok),
    .overflow   (q_overflow),
    .count      (q_count),
    .err_count  (q_err_count)
  );

  rxs_status_gen #(.DEPTH(DEPTH)) u_status (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .flush          (flush),
    .fifo_mode      (fifo_mode),
    .irq_en         (irq_en),
    .status_rd      (rd_status_strb),
    .pop_ok         (q_pop_ok),
    .overflow       (q_overflow),
    .empty          (q_empty),
    .head_err       (head_entry.err),
    .err_count      (q_err_count),
    .tx_shift_empty (tx_shift_empty),
    .tx_hold_empty  (tx_hold_empty),
    .line_status    (line_status),
    .line_irq       (line_irq)
  );

  assign rx_data = head_entry.data;

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fifo_mode,
  input logic                        irq_en,
  input logic                        wr_valid,
  input logic                        rd_data_strb,
  input logic                        rd_status_strb,
  input logic                        wr_status_strb,
  input logic                        flush,
  input logic                        full,
  input logic [$clog2(DEPTH+1)-1:0]  count,
  input logic [7:0]                  line_status,
  input logic                        line_irq
);

  // R6
  single_no_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !line_status[7]);

  // R2
  ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_status[0]) |-> ($past(rd_data_strb) || $past(flush)));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));

  // R4
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status_strb && !wr_valid && !rd_data_strb && !flush)
      |=> (line_status[4:1] == 4'b0000));

  // R7
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !rd_data_strb && !flush) |=> line_status[1]);

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !line_irq);

  // R10
  status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status_strb && !wr_valid && !rd_data_strb && !rd_status_strb && !flush)
      |=> ($stable(line_status[4:0]) && $stable(line_status[7])));

endmodule

bind rx_line_status_unit rxs_checker #(.DEPTH(DEPTH)) u_rxs_checker (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .fifo_mode      (fifo_mode),
  .irq_en         (irq_en),
  .wr_valid       (wr_valid),
  .rd_data_strb   (rd_data_strb),
  .rd_status_strb (rd_status_strb),
  .wr_status_strb (wr_status_strb),
  .flush          (flush),
  .full           (q_full),
  .count          (q_count),
  .line_status    (line_status),
  .line_irq       (line_irq)
);

// File: tb/rx_line_status_unit_bench.sv
`timescale 1ns/1ps
module rx_line_status_unit_bench;

  localparam int DEPTH = 16;
  localparam int NVEC  = 12;

  logic       clk;
  logic       rst_n;
  logic       fifo_mode;
  logic       irq_en;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       wr_parity_err;
  logic       wr_frame_err;
  logic       wr_break;
  logic       rd_data_strb;
  logic       rd_status_strb;
  logic       wr_status_strb;
  logic       tx_shift_empty;
  logic       tx_hold_empty;
  logic [7:0] rx_data;
  logic [7:0] line_status;
  logic       line_irq;

  int checks = 0;
  int errors = 0;

  rx_line_status_unit #(.DEPTH(DEPTH)) u_rx_line_status_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_mode      (fifo_mode),
    .irq_en         (irq_en),
    .wr_valid       (wr_valid),
    .wr_data        (wr_data),
    .wr_parity_err  (wr_parity_err),
    .wr_frame_err   (wr_frame_err),
    .wr_break       (wr_break),
    .rd_data_strb   (rd_data_strb),
    .rd_status_strb (rd_status_strb),
    .wr_status_strb (wr_status_strb),
    .tx_shift_empty (tx_shift_empty),
    .tx_hold_empty  (tx_hold_empty),
    .rx_data        (rx_data),
    .line_status    (line_status),
    .line_irq       (line_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {wr, data, {brk,frame,parity}, rd_data, rd_status, exp_status, exp_data}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 8'hA5, 3'b000, 1'b0, 1'b0, 8'h21, 8'hA5},
    {1'b1, 8'h3C, 3'b001, 1'b0, 1'b0, 8'hA1, 8'hA5},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'hA1, 8'hA5},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h21, 8'h3C},
    {1'b1, 8'h7E, 3'b010, 1'b0, 1'b0, 8'hA1, 8'h3C},
    {1'b1, 8'h81, 3'b100, 1'b0, 1'b0, 8'hA1, 8'h3C},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hA9, 8'h7E},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hB1, 8'h81},
    {1'b1, 8'h42, 3'b001, 1'b0, 1'b1, 8'hA1, 8'h81},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hA5, 8'h42},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h20, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic step(input logic wr, input logic [7:0] d, input logic [2:0] tags,
                      input logic rdd, input logic rds);
    wr_valid       = wr;
    wr_data        = d;
    wr_break       = tags[2];
    wr_frame_err   = tags[1];
    wr_parity_err  = tags[0];
    rd_data_strb   = rdd;
    rd_status_strb = rds;
    @(posedge clk);
    @(negedge clk);
    wr_valid       = 1'b0;
    wr_break       = 1'b0;
    wr_frame_err   = 1'b0;
    wr_parity_err  = 1'b0;
    rd_data_strb   = 1'b0;
    rd_status_strb = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n          = 1'b0;
    fifo_mode      = 1'b1;
    irq_en         = 1'b1;
    wr_valid       = 1'b0;
    wr_data        = 8'h00;
    wr_parity_err  = 1'b0;
    wr_frame_err   = 1'b0;
    wr_break       = 1'b0;
    rd_data_strb   = 1'b0;
    rd_status_strb = 1'b0;
    wr_status_strb = 1'b0;
    tx_shift_empty = 1'b0;
    tx_hold_empty  = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 status after reset", line_status, 8'h20);
    chk("R1 irq after reset", {7'd0, line_irq}, 8'h00);

    // R12: transmitter indications pass through
    tx_shift_empty = 1'b1;
    tx_hold_empty  = 1'b0;
    #1;
    chk("R12 tx bits", line_status, 8'h40);
    tx_shift_empty = 1'b0;
    tx_hold_empty  = 1'b1;
    #1;
    chk("R12 tx bits back", line_status, 8'h20);

    // vector walk: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][29], VEC[i][28:21], VEC[i][20:18], VEC[i][17], VEC[i][16]);
      chk($sformatf("R3/R5 vector %0d status", i), line_status, VEC[i][15:8]);
      if (VEC[i][8]) chk($sformatf("R2 vector %0d data", i), rx_data, VEC[i][7:0]);
      chk($sformatf("R9 vector %0d irq", i), {7'd0, line_irq},
          {7'd0, |VEC[i][12:9]});
    end

    // R7: fill to the limit, then overrun
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'h40 + 8'(i), 3'b000, 1'b0, 1'b0);
    chk("R2 full queue status", line_status, 8'h21);
    step(1'b1, 8'h99, 3'b000, 1'b0, 1'b0);
    chk("R7 overrun status", line_status, 8'h23);
    chk("R9 overrun irq", {7'd0, line_irq}, 8'h01);
    // R8: overrun and status read in one cycle
    step(1'b1, 8'h98, 3'b000, 1'b0, 1'b1);
    chk("R8 overrun beats read", line_status, 8'h23);
    // R4: read clears overrun
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    chk("R4 overrun cleared", line_status, 8'h21);
    chk("R4 irq cleared", {7'd0, line_irq}, 8'h00);
    // R7: push with pop while full is accepted
    step(1'b1, 8'hAA, 3'b000, 1'b1, 1'b0);
    chk("R7 push with pop no overrun", line_status, 8'h21);
    for (int i = 1; i < DEPTH; i++) begin
      chk("R2 order after wrap", rx_data, 8'h40 + 8'(i));
      step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    end
    chk("R7 accepted char last", rx_data, 8'hAA);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R2 drained", line_status, 8'h20);

    // R11: mode change flushes stored characters
    step(1'b1, 8'h55, 3'b010, 1'b0, 1'b0);
    step(1'b1, 8'h66, 3'b000, 1'b0, 1'b0);
    chk("R11 before switch", line_status, 8'hA9);
    fifo_mode = 1'b0;
    idle();
    chk("R11 flushed", line_status, 8'h20);

    // R6: single-register mode
    step(1'b1, 8'h11, 3'b001, 1'b0, 1'b0);
    chk("R6 tagged char no summary", line_status, 8'h25);
    step(1'b1, 8'h22, 3'b000, 1'b0, 1'b0);
    chk("R6 second char overruns", line_status, 8'h27);
    chk("R6 first char kept", rx_data, 8'h11);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    chk("R4 single mode read", line_status, 8'h21);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R6 single mode empty", line_status, 8'h20);

    // R9 / R10: enable gating and inert status write
    fifo_mode = 1'b1;
    idle();
    irq_en = 1'b0;
    step(1'b1, 8'h77, 3'b100, 1'b0, 1'b0);
    chk("R3 break head", line_status, 8'hB1);
    chk("R9 irq masked", {7'd0, line_irq}, 8'h00);
    wr_status_strb = 1'b1;
    idle();
    wr_status_strb = 1'b0;
    idle();
    chk("R10 status write inert", line_status, 8'hB1);
    chk("R10 data unchanged", rx_data, 8'h77);
    irq_en = 1'b1;
    #1;
    chk("R9 irq enabled", {7'd0, line_irq}, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule